// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight interrupt request lines on behalf of a small processor core. Each line has its own enable bit, a sticky pending bit and a programmable 3-bit priority, where a smaller number means a more urgent request. Three global controls sit on top of the per-line state: a full mask, a fault-level mask and a base-priority threshold. The block also keeps a stack of the priorities of the handlers that are currently active. Together these set a running level, and only requests more urgent than that level are offered to the core.

The core sees three signals. `take_req` with `take_vec` offers an interrupt. `take_ack` accepts the offer on handler entry. `exc_ret` marks the return from a handler. A request that is blocked, whether by a mask or by the running level, stays pending and is offered again once the block re-evaluates. That happens when a mask or the threshold is lowered, or when a return pops the stack. Configuration writes arrive on a single-cycle write port.

Sequencing is done by a two-state machine:
- `S_IDLE` moves to `S_OFFER` on *select*, when any eligible line exists. The winning line number is latched at that point.
- `S_OFFER` returns to `S_IDLE` on *accept*, when `take_ack` arrives while the offer is still valid.
- `S_OFFER` also returns to `S_IDLE` on *withdraw*, when the latched line stops being the best eligible line.
- In every other case `S_OFFER` holds.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the following hold: all enables, pending bits, priorities, masks and the threshold are zero; the active stack is empty; `run_level` is 8 (thread level); `take_req` is low.
- R2: A high `irq_in[i]` sampled on a clock edge sets pending bit i, whether or not the line is enabled or masked. The bit stays set until that line is accepted.
- R3: `take_req` is high only for a line that is enabled, pending and strictly more urgent than `run_level`. An offer appears one cycle after the pending bit is set.
- R4: Among eligible lines, the lowest priority value wins. Ties go to the lowest line number.
- R5: Writing address 2 with bit 0 set raises the full mask. This forces `run_level` to 0, so nothing is offered. Clearing the mask lets pending lines be taken.
- R6: Address 3 bit 0 is the fault-level mask and behaves exactly like R5.
- R7: Address 4 bits [2:0] hold the base threshold B. A nonzero B blocks every line whose priority value is ≥ B. A value of 0 disables the threshold.
- R8: An accepted offer (`take_req` and `take_ack` in the same cycle) has two effects. It clears that line's pending bit, and it pushes the line's priority onto the active stack, which changes `run_level`.
- R9: A request preempts a running handler only if it is strictly more urgent. An equal priority waits.
- R10: `exc_ret` pops the top stack entry, and `run_level` falls back to the next entry or to 8. When the stack is empty, `exc_ret` is ignored.
- R11: If a more urgent line becomes eligible while an offer is out, `take_req` drops in the same cycle and the better line is offered two cycles later.
- R12: Writing address 0 sets the enable bits where `wr_data` is 1. Writing address 1 clears them. A pending but disabled line is never offered. Priority of line i is written at address 8+i, bits [2:0].
- R13: The active stack holds 8 entries, never overflows, and unwinds in last-in-first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration address |
| wr_data | input | 8 | Configuration write data |
| take_req | output | 1 | Offer of an interrupt to the core |
| take_vec | output | 3 | Line number being offered |
| take_ack | input | 1 | Core accepts the offer (handler entry) |
| exc_ret | input | 1 | Core leaves the current handler |
| pend_out | output | 8 | Pending bits |
| run_level | output | 4 | Current running priority level, 8 means thread level |

## Verification
The checker watches these rules on every cycle:
- No offer appears while a mask is up.
- No offer appears at or above a nonzero threshold.
- No offer appears that is not strictly more urgent than the stack top.
- Pending bits are never lost before acceptance.
- Every accept pushes the stack exactly once, and every valid return pops it exactly once.
- The stack depth never exceeds its capacity.

The bench scenarios are needed for the rest. They show which line is chosen among ties, and that an outstanding offer is withdrawn in favour of a more urgent arrival. They show that a blocked request is eventually taken once a mask, the threshold or a handler exit lowers the running level. They also show that a nested stack unwinds to the right levels.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
package nic_pkg;
    typedef enum logic [0:0] {
        S_IDLE,
        S_OFFER
    } seq_state_t;

    // control register addresses (lower half of the address space)
    localparam int ADR_EN_SET    = 0;
    localparam int ADR_EN_CLR    = 1;
    localparam int ADR_FULL_MASK = 2;
    localparam int ADR_FAULT_MSK = 3;
    localparam int ADR_BASE_THR  = 4;
endpackage

// File: rtl/nic_regs.sv
`timescale 1ns/1ps
module nic_regs #(
    parameter int NUM_LINES = 8,
    parameter int PW        = 3,
    parameter int ADDR_W    = 4,
    localparam int VW       = $clog2(NUM_LINES),
    localparam int LOWW     = ADDR_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [NUM_LINES-1:0]    wr_data,
    input  logic [NUM_LINES-1:0]    irq_in,
    input  logic                    clr_en,
    input  logic [VW-1:0]           clr_idx,
    output logic [NUM_LINES-1:0]    en_q,
    output logic [NUM_LINES-1:0]    pend_q,
    output logic [NUM_LINES*PW-1:0] prio_flat,
    output logic                    full_q,
    output logic                    fault_q,
    output logic [PW-1:0]           base_q
);
    import nic_pkg::*;

    logic            ctrl_sel;
    logic            prio_sel;
    logic [LOWW-1:0] low_addr;

    assign ctrl_sel = wr_en && !wr_addr[ADDR_W-1];
    assign prio_sel = wr_en &&  wr_addr[ADDR_W-1];
    assign low_addr = wr_addr[LOWW-1:0];

    // enable bits: set/clear by mask write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ctrl_sel && low_addr == LOWW'(ADR_EN_SET)) begin
            en_q <= en_q | wr_data;
        end else if (ctrl_sel && low_addr == LOWW'(ADR_EN_CLR)) begin
            en_q <= en_q & ~wr_data;
        end
    end

    // global masking controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            fault_q <= 1'b0;
            base_q  <= '0;
        end else if (ctrl_sel) begin
            if (low_addr == LOWW'(ADR_FULL_MASK)) full_q  <= wr_data[0];
            if (low_addr == LOWW'(ADR_FAULT_MSK)) fault_q <= wr_data[0];
            if (low_addr == LOWW'(ADR_BASE_THR))  base_q  <= wr_data[PW-1:0];
        end
    end

    // pending bits: acceptance clear has precedence over a new request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (clr_en && clr_idx == VW'(i)) begin
                    pend_q[i] <= 1'b0;
                end else if (irq_in[i]) begin
                    pend_q[i] <= 1'b1;
                end
            end
        end
    end

    // one priority register per line
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
        logic [PW-1:0] lvl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q <= '0;
            end else if (prio_sel && wr_addr[VW-1:0] == VW'(g)) begin
                lvl_q <= wr_data[PW-1:0];
            end
        end
        assign prio_flat[g*PW +: PW] = lvl_q;
    end
endmodule

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
module nic_arbiter #(
    parameter int NUM_LINES = 8,
    parameter int PW        = 3,
    localparam int VW       = $clog2(NUM_LINES),
    localparam int LW       = PW + 1
) (
    input  logic [NUM_LINES-1:0]    en_q,
    input  logic [NUM_LINES-1:0]    pend_q,
    input  logic [NUM_LINES*PW-1:0] prio_flat,
    input  logic [LW-1:0]           run_level,
    output logic [NUM_LINES-1:0]    elig,
    output logic                    any_elig,
    output logic [VW-1:0]           best_idx
);
    logic [PW-1:0] best_lvl;

    // lowest value wins; scanning upward with a strict compare keeps the
    // lowest line number on ties
    always_comb begin
        any_elig = 1'b0;
        best_idx = '0;
        best_lvl = '1;
        elig     = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            elig[i] = en_q[i] && pend_q[i] &&
                      ({1'b0, prio_flat[i*PW +: PW]} < run_level);
            if (elig[i] && (!any_elig || prio_flat[i*PW +: PW] < best_lvl)) begin
                any_elig = 1'b1;
                best_idx = VW'(i);
                best_lvl = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/nic_stack.sv
`timescale 1ns/1ps
module nic_stack #(
    parameter int PW       = 3,
    parameter int DEPTH    = 8,
    localparam int DW      = $clog2(DEPTH + 1),
    localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW      = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [PW-1:0] push_lvl,
    output logic [DW-1:0] depth,
    output logic [LW-1:0] top_level
);
    localparam logic [LW-1:0] THREAD = LW'(1 << PW);

    logic [PW-1:0] slot [DEPTH];
    logic          full;
    logic          empty;
    logic [IW-1:0] wr_slot;
    logic [IW-1:0] top_slot;

    assign full     = (depth == DW'(DEPTH));
    assign empty    = (depth == '0);
    assign wr_slot  = IW'(depth);
    assign top_slot = IW'(depth - DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else begin
            unique case ({push, pop && !empty})
                2'b10: if (!full) begin
                    slot[wr_slot] <= push_lvl;
                    depth         <= depth + DW'(1);
                end
                2'b01: depth <= depth - DW'(1);
                2'b11: slot[top_slot] <= push_lvl;
                default: ;
            endcase
        end
    end

    assign top_level = empty ? THREAD : {1'b0, slot[top_slot]};
endmodule

// File: rtl/nic_seq.sv
`timescale 1ns/1ps
module nic_seq #(
    parameter int NUM_LINES = 8,
    localparam int VW       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] elig,
    input  logic                 any_elig,
    input  logic [VW-1:0]        best_idx,
    input  logic                 take_ack,
    output logic                 take_req,
    output logic [VW-1:0]        take_vec,
    output logic                 accept
);
    import nic_pkg::*;

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [VW-1:0] vec_q;
    logic          offer_live;

    assign offer_live = any_elig && elig[vec_q] && (best_idx == vec_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && any_elig) vec_q <= best_idx;
        end
    end

    // transitions: select, accept, withdraw
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (any_elig) state_d = S_OFFER;
            S_OFFER: begin
                if (offer_live && take_ack) state_d = S_IDLE;
                else if (!offer_live)       state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_req = (state_q == S_OFFER) && offer_live;
        take_vec = vec_q;
        accept   = take_req && take_ack;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
`timescale 1ns/1ps
module nest_irq_ctrl #(
    parameter int NUM_LINES = 8,
    parameter int PW        = 3,
    parameter int DEPTH     = 8,
    localparam int VW       = $clog2(NUM_LINES),
    localparam int ADDR_W   = ((VW > 3) ? VW : 3) + 1,
    localparam int LW       = PW + 1,
    localparam int DW       = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic                 take_req,
    output logic [VW-1:0]        take_vec,
    input  logic                 take_ack,
    input  logic                 exc_ret,
    output logic [NUM_LINES-1:0] pend_out,
    output logic [LW-1:0]        run_level
);
    localparam logic [LW-1:0] THREAD = LW'(1 << PW);

    logic [NUM_LINES-1:0]    en_q;
    logic [NUM_LINES-1:0]    pend_q;
    logic [NUM_LINES*PW-1:0] prio_flat;
    logic                    full_q;
    logic                    fault_q;
    logic [PW-1:0]           base_q;
    logic [NUM_LINES-1:0]    elig;
    logic                    any_elig;
    logic [VW-1:0]           best_idx;
    logic                    accept;
    logic [DW-1:0]           depth;
    logic [LW-1:0]           stack_top;
    logic [LW-1:0]           base_lvl;
    logic [LW-1:0]           mask_lvl;

    nic_regs #(.NUM_LINES(NUM_LINES), .PW(PW), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .irq_in    (irq_in),
        .clr_en    (accept),
        .clr_idx   (take_vec),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .prio_flat (prio_flat),
        .full_q    (full_q),
        .fault_q   (fault_q),
        .base_q    (base_q)
    );

    // running level: most urgent of stack top, threshold and mask level
    assign base_lvl = (base_q == '0) ? THREAD : {1'b0, base_q};
    assign mask_lvl = (full_q || fault_q) ? '0 : THREAD;

    always_comb begin
        run_level = stack_top;
        if (base_lvl < run_level) run_level = base_lvl;
        if (mask_lvl < run_level) run_level = mask_lvl;
    end

    nic_arbiter #(.NUM_LINES(NUM_LINES), .PW(PW)) u_arb (
        .en_q      (en_q),
        .pend_q    (pend_q),
        .prio_flat (prio_flat),
        .run_level (run_level),
        .elig      (elig),
        .any_elig  (any_elig),
        .best_idx  (best_idx)
    );

    nic_seq #(.NUM_LINES(NUM_LINES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .any_elig (any_elig),
        .best_idx (best_idx),
        .take_ack (take_ack),
        .take_req (take_req),
        .take_vec (take_vec),
        .accept   (accept)
    );

    nic_stack #(.PW(PW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .pop       (exc_ret),
        .push_lvl  (prio_flat[take_vec*PW +: PW]),
        .depth     (depth),
        .top_level (stack_top)
    );

    assign pend_out = pend_q;
endmodule

// File: rtl/nic_checker.sv
`timescale 1ns/1ps
module nic_checker #(
    parameter int NUM_LINES = 8,
    parameter int PW        = 3,
    parameter int DEPTH     = 8,
    localparam int VW       = $clog2(NUM_LINES),
    localparam int LW       = PW + 1,
    localparam int DW       = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    take_req,
    input logic [VW-1:0]           take_vec,
    input logic                    take_ack,
    input logic                    exc_ret,
    input logic [NUM_LINES-1:0]    enable,
    input logic [NUM_LINES-1:0]    pending,
    input logic [NUM_LINES*PW-1:0] prio_flat,
    input logic                    full_mask,
    input logic                    fault_mask,
    input logic [PW-1:0]           base_thr,
    input logic [DW-1:0]           depth,
    input logic [LW-1:0]           stack_top
);
    logic [PW-1:0] vec_lvl;
    logic          took;
    assign vec_lvl = prio_flat[take_vec*PW +: PW];
    assign took    = take_req && take_ack;

    p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_mask || fault_mask) |-> !take_req);

    p_base_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && base_thr != '0) |-> (vec_lvl < base_thr));

    p_offer_preempts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && depth != '0) |-> ({1'b0, vec_lvl} < stack_top));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> !pending[$past(take_vec)]);

    p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !exc_ret && depth < DW'(DEPTH)) |=> depth == $past(depth) + DW'(1));

    p_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret && !took && depth != '0) |=> depth == $past(depth) - DW'(1));

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(DEPTH));

    p_enable_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_hold
        p_pending_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[g] && !(took && take_vec == VW'(g))) |=> pending[g]);
    end
endmodule

bind nest_irq_ctrl nic_checker #(
    .NUM_LINES (NUM_LINES),
    .PW        (PW),
    .DEPTH     (DEPTH)
) u_nic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .take_req   (take_req),
    .take_vec   (take_vec),
    .take_ack   (take_ack),
    .exc_ret    (exc_ret),
    .enable     (en_q),
    .pending    (pend_q),
    .prio_flat  (prio_flat),
    .full_mask  (full_q),
    .fault_mask (fault_q),
    .base_thr   (base_q),
    .depth      (depth),
    .stack_top  (stack_top)
);

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
    localparam int NL = 8;
    localparam int VW = 3;
    localparam int AW = 4;
    localparam int LW = 4;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic [NL-1:0] irq_in   = '0;
    logic          wr_en    = 1'b0;
    logic [AW-1:0] wr_addr  = '0;
    logic [NL-1:0] wr_data  = '0;
    logic          take_ack = 1'b0;
    logic          exc_ret  = 1'b0;
    logic          take_req;
    logic [VW-1:0] take_vec;
    logic [NL-1:0] pend_out;
    logic [LW-1:0] run_level;

    int            n_checks = 0;
    int            n_fail   = 0;
    bit            auto_ack = 1'b0;
    int            exp_q[$];

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    nest_irq_ctrl i_nest_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .take_req  (take_req),
        .take_vec  (take_vec),
        .take_ack  (take_ack),
        .exc_ret   (exc_ret),
        .pend_out  (pend_out),
        .run_level (run_level)
    );

    task automatic chk_eq(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each offer and acknowledges it
    always @(negedge clk) begin
        if (take_ack) begin
            take_ack <= 1'b0;
        end else if (auto_ack && take_req) begin
            if (exp_q.size() == 0) begin
                chk_eq("R3 unexpected offer", int'(take_vec), -1);
            end else begin
                chk_eq("R4 offered line", int'(take_vec), exp_q.pop_front());
            end
            take_ack <= 1'b1;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = NL'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic req(int m);
        irq_in = NL'(m);
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic ret();
        exc_ret = 1'b1;
        @(negedge clk);
        exc_ret = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        step(3);
        chk_eq("R1 pending after reset", int'(pend_out), 0);
        chk_eq("R1 take_req after reset", int'(take_req), 0);
        chk_eq("R1 run_level after reset", int'(run_level), 8);
        rst_n = 1'b1;
        step(1);

        // priorities: line -> 4,4,2,5,6,1,3,6 (R12 address 8+i)
        wr(8, 4); wr(9, 4); wr(10, 2); wr(11, 5);
        wr(12, 6); wr(13, 1); wr(14, 3); wr(15, 6);
        auto_ack = 1'b1;

        // R2 / R12: disabled line stays pending, not offered
        req(8'h01); step(4);
        chk_eq("R2 pending while disabled", int'(pend_out), 8'h01);
        chk_eq("R12 disabled not offered", int'(take_req), 0);
        chk_eq("R12 run_level idle", int'(run_level), 8);

        // R12 / R8: enabling lets it through, accept pushes level 4
        exp_q.push_back(0);
        wr(0, 8'hFF); step(4);
        chk_eq("R8 run_level after accept", int'(run_level), 4);
        chk_eq("R8 pending cleared", int'(pend_out), 0);

        // R9: equal priority waits; R10: taken after return
        req(8'h02); step(4);
        chk_eq("R9 equal level pending", int'(pend_out), 8'h02);
        chk_eq("R9 equal level run_level", int'(run_level), 4);
        exp_q.push_back(1);
        ret(); step(4);
        chk_eq("R10 pending taken after return", int'(pend_out), 0);
        chk_eq("R10 run_level after re-entry", int'(run_level), 4);
        ret(); step(2);
        chk_eq("R10 back to thread", int'(run_level), 8);
        ret(); step(2);
        chk_eq("R10 empty return ignored", int'(run_level), 8);
        chk_eq("R10 empty return no offer", int'(take_req), 0);

        // R4 tie break and R11 withdraw
        auto_ack = 1'b0;
        req(8'h90); step(1);
        chk_eq("R3 offer present", int'(take_req), 1);
        chk_eq("R4 tie lowest line", int'(take_vec), 4);
        req(8'h08);
        chk_eq("R11 offer withdrawn", int'(take_req), 0);
        step(1);
        chk_eq("R11 idle between offers", int'(take_req), 0);
        step(1);
        chk_eq("R11 better line offered", int'(take_req), 1);
        chk_eq("R11 better line vector", int'(take_vec), 3);
        exp_q.push_back(3);
        auto_ack = 1'b1;
        step(3);
        chk_eq("R8 run_level line3", int'(run_level), 5);
        chk_eq("R2 lower lines kept", int'(pend_out), 8'h90);
        exp_q.push_back(4);
        ret(); step(4);
        chk_eq("R9 run_level line4", int'(run_level), 6);
        chk_eq("R9 equal line7 waits", int'(pend_out), 8'h80);
        exp_q.push_back(7);
        ret(); step(4);
        chk_eq("R10 line7 after return", int'(run_level), 6);
        ret(); step(2);
        chk_eq("R10 thread again", int'(run_level), 8);

        // R9 preemption by more urgent line
        exp_q.push_back(3);
        req(8'h08); step(4);
        exp_q.push_back(5);
        req(8'h20); step(4);
        chk_eq("R9 preempted to level 1", int'(run_level), 1);
        ret(); step(2);
        chk_eq("R10 resume level 5", int'(run_level), 5);
        ret(); step(2);

        // R5 full mask
        wr(2, 1); step(1);
        chk_eq("R5 masked run_level", int'(run_level), 0);
        req(8'h20); step(4);
        chk_eq("R5 masked pending", int'(pend_out), 8'h20);
        chk_eq("R5 masked no offer", int'(take_req), 0);
        exp_q.push_back(5);
        wr(2, 0); step(4);
        chk_eq("R5 taken on unmask", int'(run_level), 1);
        ret(); step(2);

        // R6 fault-level mask
        wr(3, 1); step(1);
        chk_eq("R6 masked run_level", int'(run_level), 0);
        req(8'h04); step(4);
        chk_eq("R6 masked pending", int'(pend_out), 8'h04);
        exp_q.push_back(2);
        wr(3, 0); step(4);
        chk_eq("R6 taken on unmask", int'(run_level), 2);
        ret(); step(2);

        // R7 base threshold 3
        wr(4, 3); step(1);
        chk_eq("R7 threshold level", int'(run_level), 3);
        req(8'h40); step(4);
        chk_eq("R7 equal to threshold blocked", int'(pend_out), 8'h40);
        exp_q.push_back(2);
        req(8'h04); step(4);
        chk_eq("R7 above threshold taken", int'(run_level), 2);
        ret(); step(2);
        chk_eq("R7 back to threshold", int'(run_level), 3);
        exp_q.push_back(6);
        wr(4, 0); step(4);
        chk_eq("R7 zero disables threshold", int'(pend_out), 0);
        chk_eq("R7 line6 running", int'(run_level), 3);
        ret(); step(2);

        // R12 enable clear
        wr(1, 8'h01);
        req(8'h01); step(4);
        chk_eq("R12 cleared enable blocks", int'(run_level), 8);
        exp_q.push_back(0);
        wr(0, 8'h01); step(4);
        chk_eq("R12 re-enabled taken", int'(run_level), 4);
        ret(); step(2);

        // R13 six-deep nesting and unwind
        exp_q.push_back(4); req(8'h10); step(4);
        exp_q.push_back(3); req(8'h08); step(4);
        exp_q.push_back(0); req(8'h01); step(4);
        exp_q.push_back(6); req(8'h40); step(4);
        exp_q.push_back(2); req(8'h04); step(4);
        exp_q.push_back(5); req(8'h20); step(4);
        chk_eq("R13 deepest level", int'(run_level), 1);
        ret(); step(2);
        chk_eq("R13 unwind order", int'(run_level), 2);
        ret(); step(2);
        chk_eq("R13 unwind order 2", int'(run_level), 3);
        ret(); ret(); ret(); ret(); step(2);
        chk_eq("R13 fully unwound", int'(run_level), 8);

        chk_eq("R3 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule